// File: doc/BRIEF.md
# Buffered Burst Serial Port

This block is one channel of a clocked serial link with a built-in store of byte slots. The host places up to eight bytes into the slots through an addressed write port. It then issues a single start with a byte count, and the channel shifts that many bytes out on its own. Every byte received in exchange replaces the slot its outgoing byte came from, so once the burst ends the host reads the replies back from the same addresses.

The channel either generates the serial clock itself or follows a clock driven from outside. In the second case the incoming clock and data are brought into the system clock domain through two-flop synchronizers, and edges are detected there. An optional select mode adds an active-low select input. While this input is high the transfer is held and the data and clock drivers are released. The pads themselves are outside the block, so the tristate behaviour is presented as output-enable signals.

Top module: `sio_burst_port`

## Requirements
- R1: After reset, busy and done_irq are 0, sck_o and so_o are 1, and every slot reads 0.
- R2: When idle, a host write stores host_wdata into slot host_addr, and host_rdata shows the slot selected by host_addr in the same cycle. A host write while busy is ignored.
- R3: A start with xfer_count n (1 to 7) sends slots 0 to n-1 in that order. Each byte goes most significant bit first, and so_o takes the next bit on each falling SCK edge.
- R4: An xfer_count of 0 sends all 8 slots.
- R5: si is sampled on each rising SCK edge, most significant bit first. The byte received during byte k overwrites slot k.
- R6: busy rises on the clock edge that accepts a start. It falls on the edge of the last rising SCK edge of the last byte. done_irq is high for exactly the one cycle after busy falls.
- R7: A start while busy is ignored: the burst length does not change and no extra burst follows.
- R8: With cfg_master=1, sck_oe is 1 (outside select mode) and sck_o idles high. Each SCK phase lasts 2^cfg_div system clock cycles, and the first edge of a burst is a falling edge.
- R9: With cfg_master=0, sck_oe is 0. The transfer advances on edges of sck_i, and both sck_i and si pass through two-flop synchronizers.
- R10: With cfg_cs_mode=1 and cs_n high, so_oe and sck_oe are 0 and no bit advances. Pulling cs_n low resumes the burst. With cfg_cs_mode=0, so_oe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1: generate SCK, 0: follow sck_i |
| cfg_cs_mode | input | 1 | Enable select gating by cs_n |
| cfg_div | input | DIVW | SCK phase length exponent in master mode |
| host_we | input | 1 | Write strobe for a slot |
| host_addr | input | AW | Slot address for write and read |
| host_wdata | input | DW | Byte to store |
| host_rdata | output | DW | Content of the addressed slot |
| xfer_count | input | AW | Bytes per burst, 0 meaning DEPTH |
| xfer_start | input | 1 | Start a burst |
| busy | output | 1 | Burst in progress |
| done_irq | output | 1 | One-cycle end-of-burst interrupt request |
| sck_i | input | 1 | External serial clock (slave) |
| sck_o | output | 1 | Generated serial clock (master) |
| sck_oe | output | 1 | Drive enable for sck_o |
| si | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe | output | 1 | Drive enable for so_o |
| cs_n | input | 1 | Active-low select |

## Verification
The bench builds the block with its defaults: eight one-byte slots, a three-bit count and a two-bit divider selector. With these values, every burst length including the wrap of count 0 to eight can be reached, along with all four SCK phase lengths from one to eight system cycles. Random master bursts cover varied divider, length and data. Slave bursts use an external SCK phase of six cycles, which leaves room for the synchronizer delay, and the select gating is exercised in both clock roles.

// File: rtl/sio_pkg.sv
package sio_pkg;
  // system clock cycles per SCK phase for a divider setting
  function automatic int unsigned half_cycles(input int unsigned sel);
    return 32'd1 << sel;
  endfunction

  // index of the final slot of a burst; count 0 selects the whole store
  function automatic int unsigned last_slot(input int unsigned cnt, input int unsigned depth);
    return (cnt == 0) ? depth - 1 : cnt - 1;
  endfunction
endpackage

// File: rtl/sio_buf.sv
module sio_buf #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_waddr,
  input  logic [DW-1:0] eng_wdata,
  input  logic [AW-1:0] eng_raddr,
  output logic [DW-1:0] eng_rdata
);
  logic [DW-1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  slot[g] <= '0;
      else if (eng_we && eng_waddr == AW'(g))      slot[g] <= eng_wdata;
      else if (host_we && host_addr == AW'(g))     slot[g] <= host_wdata;
    end
  end

  assign host_rdata = slot[host_addr];
  assign eng_rdata  = slot[eng_raddr];
endmodule

// File: rtl/sio_sck_unit.sv
module sio_sck_unit #(
  parameter int DIVW  = 2,
  localparam int CW   = (1 << DIVW) - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            master,
  input  logic            enable,
  input  logic            running,
  input  logic [DIVW-1:0] div_sel,
  input  logic            sck_i,
  input  logic            si_i,
  output logic            sck_o,
  output logic            si_s,
  output logic            rise_ev,
  output logic            fall_ev
);
  import sio_pkg::*;

  // slave path: two-flop synchronizers plus one history flop for edges
  logic sck_s1, sck_s2, sck_s3, si_s1, si_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s1 <= 1'b1; sck_s2 <= 1'b1; sck_s3 <= 1'b1;
      si_s1  <= 1'b0; si_s2  <= 1'b0;
    end else begin
      sck_s1 <= sck_i; sck_s2 <= sck_s1; sck_s3 <= sck_s2;
      si_s1  <= si_i;  si_s2  <= si_s1;
    end
  end
  wire s_rise = sck_s2 & ~sck_s3;
  wire s_fall = ~sck_s2 & sck_s3;

  // master path: phase counter toggles the generated clock
  logic [CW-1:0] cnt_q;
  logic          sck_q;
  wire gen_on = master && running && enable;
  wire m_tick = gen_on &&
                ({{(32-CW){1'b0}}, cnt_q} == half_cycles(32'(div_sel)) - 32'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!gen_on || m_tick) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sck_q <= 1'b1;
    else if (m_tick)   sck_q <= ~sck_q;
    else if (!running) sck_q <= 1'b1;
  end

  assign sck_o   = sck_q;
  assign rise_ev = master ? (m_tick && !sck_q) : (s_rise && running && enable);
  assign fall_ev = master ? (m_tick &&  sck_q) : (s_fall && running && enable);
  assign si_s    = master ? si_i : si_s2;

  p_sck_idle_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && $past(!running)) |-> sck_o);
  p_one_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_ev, fall_ev}));
endmodule

// File: rtl/sio_engine.sv
module sio_engine #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int BW   = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] count,
  input  logic          rise_ev,
  input  logic          fall_ev,
  input  logic          si_s,
  input  logic [DW-1:0] buf_rdata,
  output logic [AW-1:0] buf_raddr,
  output logic          buf_we,
  output logic [AW-1:0] buf_waddr,
  output logic [DW-1:0] buf_wdata,
  output logic          busy,
  output logic          done,
  output logic          so
);
  import sio_pkg::*;

  logic          busy_q, done_q, so_q;
  logic [AW-1:0] idx_q, last_q;
  logic [BW-1:0] bit_q;
  logic [DW-1:0] tx_q, rx_q;

  wire start_acc = start && !busy_q;
  wire byte_end  = busy_q && rise_ev && (bit_q == BW'(DW-1));
  wire last_byte = (idx_q == last_q);

  assign buf_raddr = busy_q ? idx_q + AW'(1) : '0;
  assign buf_we    = byte_end;
  assign buf_waddr = idx_q;
  assign buf_wdata = {rx_q[DW-2:0], si_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; so_q <= 1'b1;
      idx_q <= '0; last_q <= '0; bit_q <= '0;
      tx_q <= '0; rx_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_acc) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        bit_q  <= '0;
        last_q <= AW'(last_slot(32'(count), DEPTH));
        tx_q   <= buf_rdata;
      end else if (busy_q) begin
        if (fall_ev) begin
          so_q <= tx_q[DW-1];
          tx_q <= {tx_q[DW-2:0], 1'b0};
        end
        if (rise_ev) begin
          rx_q <= {rx_q[DW-2:0], si_s};
          if (bit_q == BW'(DW-1)) begin
            bit_q <= '0;
            if (last_byte) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              idx_q <= idx_q + AW'(1);
              tx_q  <= buf_rdata;
            end
          end else begin
            bit_q <= bit_q + BW'(1);
          end
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign so   = so_q;

  p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q)));
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy_q) |=> $stable(last_q));
endmodule

// File: rtl/sio_burst_port.sv
module sio_burst_port #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  parameter int DIVW  = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_master,
  input  logic            cfg_cs_mode,
  input  logic [DIVW-1:0] cfg_div,
  input  logic            host_we,
  input  logic [AW-1:0]   host_addr,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  input  logic [AW-1:0]   xfer_count,
  input  logic            xfer_start,
  output logic            busy,
  output logic            done_irq,
  input  logic            sck_i,
  output logic            sck_o,
  output logic            sck_oe,
  input  logic            si,
  output logic            so_o,
  output logic            so_oe,
  input  logic            cs_n
);
  // select input synchronized for gating the bit progress
  logic cs_s1, cs_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin cs_s1 <= 1'b1; cs_s2 <= 1'b1; end
    else        begin cs_s1 <= cs_n; cs_s2 <= cs_s1; end
  end
  wire xfer_en = !cfg_cs_mode || !cs_s2;

  logic          rise_ev, fall_ev, si_s;
  logic          buf_we;
  logic [AW-1:0] buf_raddr, buf_waddr;
  logic [DW-1:0] buf_rdata, buf_wdata;

  sio_buf #(.DEPTH(DEPTH), .DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we && !busy), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .eng_we(buf_we), .eng_waddr(buf_waddr), .eng_wdata(buf_wdata),
    .eng_raddr(buf_raddr), .eng_rdata(buf_rdata)
  );

  sio_sck_unit #(.DIVW(DIVW)) u_sck (
    .clk(clk), .rst_n(rst_n), .master(cfg_master), .enable(xfer_en),
    .running(busy), .div_sel(cfg_div), .sck_i(sck_i), .si_i(si),
    .sck_o(sck_o), .si_s(si_s), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  sio_engine #(.DEPTH(DEPTH), .DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(xfer_start), .count(xfer_count),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .si_s(si_s),
    .buf_rdata(buf_rdata), .buf_raddr(buf_raddr), .buf_we(buf_we),
    .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .busy(busy), .done(done_irq), .so(so_o)
  );

  assign so_oe  = !cfg_cs_mode || !cs_n;
  assign sck_oe = cfg_master && so_oe;

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);
endmodule

// File: tb/tb_sio_burst_port.sv
module tb_sio_burst_port;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cfg_master, cfg_cs_mode, host_we, xfer_start, sck_i, si, cs_n;
  logic [1:0] cfg_div;
  logic [2:0] host_addr, xfer_count;
  logic [7:0] host_wdata, host_rdata;
  logic busy, done_irq, sck_o, sck_oe, so_o, so_oe;

  sio_burst_port dut (.*);

  int nchk = 0, nerr = 0, dcount = 0, cycles = 0;
  logic [7:0] txb [8];
  logic [7:0] rxb [8];
  logic [7:0] got [8];

  function automatic int exp_len(input int c); return (c == 0) ? 8 : c; endfunction
  function automatic int exp_half(input int d); return 1 << d; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin nerr++; $display("FAIL %s actual %0h expected %0h", req, act, exp); end
  endtask

  always @(negedge clk) if (done_irq) dcount++;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nerr++; $display("FAIL watchdog actual %0d expected 0", cycles);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr); $finish;
    end
  end

  task automatic host_write(input int a, input logic [7:0] d);
    @(negedge clk); host_we = 1; host_addr = 3'(a); host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask
  task automatic load_all();
    for (int k = 0; k < 8; k++) host_write(k, txb[k]);
  endtask
  task automatic go(input int c);
    @(negedge clk); xfer_count = 3'(c); xfer_start = 1;
    @(negedge clk); xfer_start = 0;
  endtask
  task automatic fill_random();
    for (int k = 0; k < 8; k++) begin txb[k] = 8'($urandom); rxb[k] = 8'($urandom); got[k] = 0; end
  endtask

  task automatic master_run(input int nbytes, input int div, input bit poke, input string endreq);
    int cyc = 0, tot = 0, rises = 0, falls = 0, bad = 0;
    bit first = 1;
    logic prev = sck_o;
    while (rises < nbytes * 8 && tot < 4000) begin
      @(negedge clk); cyc++; tot++;
      if (poke && tot == 3) begin
        xfer_start = 1; xfer_count = 3'd5;
        host_we = 1; host_addr = 3'd7; host_wdata = 8'hEE;
      end
      if (poke && tot == 4) begin xfer_start = 0; host_we = 0; end
      if (sck_o !== prev) begin
        if (!first && cyc != exp_half(div)) bad++;
        first = 0; cyc = 0;
        if (prev == 1'b1) begin si = rxb[falls / 8][7 - falls % 8]; falls++; end
        else begin got[rises / 8] = {got[rises / 8][6:0], so_o}; rises++; end
        prev = sck_o;
      end
    end
    chk(busy == 1'b0, endreq, busy, 0);
    chk(done_irq == 1'b1, "R6 done pulse", done_irq, 1);
    chk(bad == 0, "R8 phase length", bad, 0);
  endtask

  task automatic slave_run(input int nbytes, input int half);
    for (int b = 0; b < nbytes; b++)
      for (int i = 0; i < 8; i++) begin
        @(negedge clk); sck_i = 0; si = rxb[b][7 - i];
        repeat (half) @(negedge clk);
        got[b] = {got[b][6:0], so_o}; sck_i = 1;
        repeat (half - 1) @(negedge clk);
      end
    repeat (6) @(negedge clk);
    chk(busy == 1'b0, "R9 slave burst end", busy, 0);
  endtask

  task automatic verify(input int n);
    for (int k = 0; k < n; k++) begin
      chk(got[k] == txb[k], "R3 sent byte", got[k], txb[k]);
      host_addr = 3'(k); #1;
      chk(host_rdata == rxb[k], "R5 stored reply", host_rdata, rxb[k]);
    end
  endtask

  initial begin
    int c, d, d0;
    void'($urandom(32'd4242));
    rst_n = 0; cfg_master = 1; cfg_cs_mode = 0; cfg_div = 0; host_we = 0;
    host_addr = 0; host_wdata = 0; xfer_count = 0; xfer_start = 0;
    sck_i = 1; si = 0; cs_n = 1;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done_irq == 0, "R1 flags", {busy, done_irq}, 0);
    chk(sck_o == 1 && so_o == 1, "R1 lines", {sck_o, so_o}, 3);
    for (int k = 0; k < 8; k++) begin
      host_addr = 3'(k); #1; chk(host_rdata == 0, "R1 slot", host_rdata, 0);
    end
    chk(so_oe == 1 && sck_oe == 1, "R10 drivers on without select mode", {so_oe, sck_oe}, 3);

    // random master bursts, first two directed to count 0 and count 1
    for (int t = 0; t < 7; t++) begin
      fill_random(); load_all();
      host_addr = 3'd3; #1;
      chk(host_rdata == txb[3], "R2 readback", host_rdata, txb[3]);
      for (int k = 0; k < 8; k++) rxb[k] = rxb[k];
      c = (t == 0) ? 0 : (t == 1) ? 1 : int'($urandom % 8);
      d = int'($urandom % 4);
      cfg_div = 2'(d);
      d0 = dcount;
      go(c);
      master_run(exp_len(c), d, 0, (c == 0) ? "R4 eight bytes" : "R6 busy end");
      verify(exp_len(c));
      @(negedge clk);
      chk(dcount == d0 + 1, "R6 one done", dcount, d0 + 1);
    end

    // start and host write while busy are both ignored
    fill_random(); txb[7] = 8'h5A; load_all();
    cfg_div = 2'd1; d0 = dcount;
    go(2);
    master_run(2, 1, 1, "R7 length kept");
    verify(2);
    host_addr = 3'd7; #1;
    chk(host_rdata == 8'h5A, "R2 write while busy", host_rdata, 8'h5A);
    repeat (40) @(negedge clk);
    chk(busy == 0 && dcount == d0 + 1, "R7 no extra burst", dcount, d0 + 1);

    // master in select mode: held while cs_n high
    fill_random(); load_all();
    cfg_cs_mode = 1; cs_n = 1; cfg_div = 2'd0;
    go(1);
    repeat (40) @(negedge clk);
    chk(busy == 1 && sck_o == 1, "R10 master held", {busy, sck_o}, 3);
    chk(so_oe == 0 && sck_oe == 0, "R10 master float", {so_oe, sck_oe}, 0);
    cs_n = 0;
    master_run(1, 0, 0, "R10 resumed");
    verify(1);
    cfg_cs_mode = 0; cs_n = 1;

    // slave bursts
    cfg_master = 0;
    @(negedge clk);
    chk(sck_oe == 0, "R9 sck released", sck_oe, 0);
    for (int t = 0; t < 2; t++) begin
      fill_random(); load_all();
      c = 1 + int'($urandom % 3);
      go(c);
      slave_run(c, 6);
      verify(c);
    end

    // slave in select mode: clock pulses ignored while cs_n high
    fill_random(); load_all();
    cfg_cs_mode = 1; cs_n = 1;
    go(1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sck_i = 0; si = 1;
      repeat (6) @(negedge clk); sck_i = 1;
      repeat (5) @(negedge clk);
    end
    chk(busy == 1, "R10 slave held", busy, 1);
    chk(so_oe == 0, "R10 so float", so_oe, 0);
    cs_n = 0;
    repeat (5) @(negedge clk);
    chk(so_oe == 1, "R10 so driven", so_oe, 1);
    slave_run(1, 6);
    verify(1);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule